// File: doc/BRIEF.md
# Smart Card Character Receiver

This block receives characters from the I/O line of an asynchronous smart card interface. A baud generator outside the block supplies a one-cycle strobe at the middle of each bit period. On each strobe the block samples the line. It first looks for a low start bit, then shifts in eight data bits with the least significant bit first, and then takes a parity bit. It checks the parity of the character against an even/odd selection. A byte that passes is placed in a receive data register, and a data-ready flag is raised.

A parity failure sets a sticky error flag, and reception carries on while that flag is high. The mode input decides what happens to a failed byte. In character mode (T=0) the byte is dropped: the data register and the ready flag do not change. In block mode (T=1) the byte is delivered and marked ready just like a good one. Software clears either flag by writing a 0 to its bit. Writing a 1 leaves the flag as it is. When a new event and a clearing write fall in the same cycle, the event wins.

Top module: `sc_char_rx`

## Requirements
- R1: A frame is one low start bit, 8 data bits sent LSB first, then one parity bit. The line is sampled only in cycles where `bit_tick` is 1. While idle, a low line without a tick does not start a frame.
- R2: A character is bad when the XOR of its 8 data bits and its parity bit differs from `odd_par`. With `odd_par`=0 (even), the total count of ones must be even. With `odd_par`=1 (odd), it must be odd.
- R3: A good character is written to `rx_data` and sets `rx_ready` in the clock edge that samples its parity bit. A good character leaves `par_err` unchanged.
- R4: A bad character sets `par_err`. `par_err` stays 1 through later good characters.
- R5: `par_err` is cleared only by reset or by a write with `wr_data[1]`=0. A write with `wr_data[1]`=1 leaves it unchanged.
- R6: With `mode_t1`=0 (T=0), a bad character changes neither `rx_data` nor `rx_ready`.
- R7: With `mode_t1`=1 (T=1), a bad character is written to `rx_data` and sets `rx_ready`.
- R8: Characters keep being received and delivered while `par_err` is 1.
- R9: With `rx_en`=0, a frame in progress is abandoned and `rx_data`, `rx_ready` and `par_err` keep their values.
- R10: If a set condition and a clearing write to the same flag fall in one cycle, the flag is set.
- R11: A write with `wr_data[0]`=0 clears `rx_ready`. A write with `wr_data[0]`=1 leaves it unchanged.
- R12: After reset, `rx_data` is 0x00 and `rx_ready` and `par_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| mode_t1 | input | 1 | 0: character mode (T=0), 1: block mode (T=1) |
| odd_par | input | 1 | 0: even parity, 1: odd parity |
| bit_tick | input | 1 | Mid-bit sample strobe |
| rx_line | input | 1 | Serial line, idle high |
| wr_en | input | 1 | Flag write strobe |
| wr_data | input | 2 | Bit 0: write 0 clears ready; bit 1: write 0 clears parity error |
| rx_data | output | 8 | Receive data register |
| rx_ready | output | 1 | Receive data ready flag |
| par_err | output | 1 | Sticky parity error flag |

## Verification
The hardest case to reach is a clearing write that lands in the same cycle as a parity failure in block mode, because both flags are then set and cleared at once. The bench reaches it by lining up the software write with the strobe that samples the parity bit. A second hard case is dropping the enable in the middle of a frame. The bench first checks that all outputs stay frozen. It then sends a fresh complete character, which shows that no leftover bit count carried over.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

    localparam int CHAR_W   = 8;
    localparam int WB_READY = 0;
    localparam int WB_PERR  = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_PAR
    } rx_state_e;

    typedef struct packed {
        logic clr_perr;
        logic clr_ready;
    } flag_clr_t;

    typedef struct packed {
        logic load;
        logic perr_set;
    } evt_act_t;

    // 1 when the received ones count does not match the selected sense
    function automatic logic parity_bad(logic data_xor, logic pbit, logic odd_sel);
        return data_xor ^ pbit ^ odd_sel;
    endfunction

endpackage

// File: rtl/sc_rx_frame.sv
module sc_rx_frame
    import sc_rx_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_en,
    input  logic         bit_tick,
    input  logic         rx_line,
    input  logic         odd_par,
    output logic         evt_valid,
    output logic         evt_bad,
    output logic [W-1:0] evt_data
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;

    rx_state_e      state;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]   shreg;

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (bit_tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (!rx_line) begin
                        state <= ST_DATA;
                        cnt   <= '0;
                    end
                end
                ST_DATA: begin
                    if (cnt == CNT_W'(W - 1)) state <= ST_PAR;
                    else                      cnt   <= cnt + 1'b1;
                end
                ST_PAR:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (rx_en && bit_tick && state == ST_DATA) begin
            shreg <= {rx_line, shreg[W-1:1]};
        end
    end

    assign evt_valid = rx_en && bit_tick && (state == ST_PAR);
    assign evt_data  = shreg;
    assign evt_bad   = parity_bad(^shreg, rx_line, odd_par);

    AST_SINGLE_EVT: assert property (@(posedge clk) disable iff (rst)
        evt_valid |=> !evt_valid); // R1

    AST_START_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !bit_tick) |=> state == ST_IDLE); // R1

endmodule

// File: rtl/sc_rx_flags.sv
module sc_rx_flags
    import sc_rx_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_t1,
    input  logic         evt_valid,
    input  logic         evt_bad,
    input  logic [W-1:0] evt_data,
    input  logic         wr_en,
    input  logic [1:0]   wr_data,
    output logic [W-1:0] rx_data,
    output logic         rx_ready,
    output logic         par_err
);
    flag_clr_t clr;
    evt_act_t  act;

    always_comb begin
        clr.clr_ready = wr_en && !wr_data[WB_READY];
        clr.clr_perr  = wr_en && !wr_data[WB_PERR];
        act.load      = evt_valid && (!evt_bad || mode_t1);
        act.perr_set  = evt_valid && evt_bad;
    end

    always_ff @(posedge clk) begin
        if (rst)                rx_data <= '0;
        else if (act.load)      rx_data <= evt_data;
    end

    always_ff @(posedge clk) begin
        if (rst)                rx_ready <= 1'b0;
        else if (act.load)      rx_ready <= 1'b1;
        else if (clr.clr_ready) rx_ready <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                par_err <= 1'b0;
        else if (act.perr_set)  par_err <= 1'b1;
        else if (clr.clr_perr)  par_err <= 1'b0;
    end

    AST_PERR_SET: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_bad) |=> par_err); // R4

    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (par_err && !(wr_en && !wr_data[1])) |=> par_err); // R5

    AST_PERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(par_err) |-> $past(evt_valid && evt_bad)); // R2

    AST_T0_DROP: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_bad && !mode_t1) |=> $stable(rx_data)); // R6

    AST_T1_DELIVER: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_bad && mode_t1) |=> (rx_ready && rx_data == $past(evt_data))); // R7

    AST_GOOD_LOAD: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !evt_bad) |=> rx_ready); // R3

endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
    import sc_rx_pkg::*;
#(
    parameter int DATA_W = CHAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              mode_t1,
    input  logic              odd_par,
    input  logic              bit_tick,
    input  logic              rx_line,
    input  logic              wr_en,
    input  logic [1:0]        wr_data,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              par_err
);
    logic              evt_valid;
    logic              evt_bad;
    logic [DATA_W-1:0] evt_data;

    sc_rx_frame #(.W(DATA_W)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .rx_en     (rx_en),
        .bit_tick  (bit_tick),
        .rx_line   (rx_line),
        .odd_par   (odd_par),
        .evt_valid (evt_valid),
        .evt_bad   (evt_bad),
        .evt_data  (evt_data)
    );

    sc_rx_flags #(.W(DATA_W)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .mode_t1   (mode_t1),
        .evt_valid (evt_valid),
        .evt_bad   (evt_bad),
        .evt_data  (evt_data),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready),
        .par_err   (par_err)
    );

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !wr_en) |=> ($stable(par_err) && $stable(rx_ready) && $stable(rx_data))); // R9

endmodule

// File: tb/tb_sc_char_rx.sv
module tb_sc_char_rx;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_en, mode_t1, odd_par, bit_tick, rx_line, wr_en;
    logic [1:0] wr_data;
    logic [7:0] rx_data;
    logic       rx_ready, par_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk; // 125 MHz

    sc_char_rx dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .mode_t1(mode_t1), .odd_par(odd_par),
        .bit_tick(bit_tick), .rx_line(rx_line), .wr_en(wr_en), .wr_data(wr_data),
        .rx_data(rx_data), .rx_ready(rx_ready), .par_err(par_err)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic [7:0] d, input logic r, input logic p);
        check({tag, " data"}, rx_data, d);
        check({tag, " ready"}, {7'b0, rx_ready}, {7'b0, r});
        check({tag, " perr"}, {7'b0, par_err}, {7'b0, p});
    endtask

    // One bit period of 4 cycles; the strobe sits in the last one
    task automatic tick_bit(input logic b, input logic do_wr, input logic [1:0] w);
        rx_line = b;
        repeat (3) @(negedge clk);
        bit_tick = 1'b1;
        if (do_wr) begin
            wr_en   = 1'b1;
            wr_data = w;
        end
        @(negedge clk);
        bit_tick = 1'b0;
        wr_en    = 1'b0;
    endtask

    task automatic send_char(input logic [7:0] d, input logic p,
                             input logic wr_on_par, input logic [1:0] w);
        tick_bit(1'b0, 1'b0, 2'b11);
        for (int i = 0; i < 8; i++) tick_bit(d[i], 1'b0, 2'b11);
        tick_bit(p, wr_on_par, w);
        tick_bit(1'b1, 1'b0, 2'b11);
    endtask

    task automatic sw_write(input logic [1:0] w);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic t_reset();
        check_all("R12 reset", 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_good_even();
        send_char(8'hA5, 1'b0, 1'b0, 2'b11);
        check_all("R1 R3 good even", 8'hA5, 1'b1, 1'b0);
    endtask

    task automatic t_clear_ready();
        sw_write(2'b10);
        check_all("R11 clear ready", 8'hA5, 1'b0, 1'b0);
    endtask

    task automatic t_odd();
        odd_par = 1'b1;
        send_char(8'h3C, 1'b1, 1'b0, 2'b11);
        check_all("R2 odd good", 8'h3C, 1'b1, 1'b0);
        sw_write(2'b10);
        odd_par = 1'b0;
    endtask

    task automatic t_t0_err();
        send_char(8'h0F, 1'b1, 1'b0, 2'b11);
        check_all("R6 R4 t0 error", 8'h3C, 1'b0, 1'b1);
    endtask

    task automatic t_sticky();
        send_char(8'h81, 1'b0, 1'b0, 2'b11);
        check_all("R4 R8 sticky", 8'h81, 1'b1, 1'b1);
    endtask

    task automatic t_write_one();
        sw_write(2'b11);
        check_all("R5 R11 write ones", 8'h81, 1'b1, 1'b1);
    endtask

    task automatic t_rxen();
        tick_bit(1'b0, 1'b0, 2'b11);
        for (int i = 0; i < 3; i++) tick_bit(1'b0, 1'b0, 2'b11);
        rx_en = 1'b0;
        for (int i = 0; i < 4; i++) tick_bit(1'b0, 1'b0, 2'b11);
        check_all("R9 disabled hold", 8'h81, 1'b1, 1'b1);
        rx_line = 1'b1;
        @(negedge clk);
        rx_en = 1'b1;
        send_char(8'h96, 1'b0, 1'b0, 2'b11);
        check_all("R9 R8 fresh frame", 8'h96, 1'b1, 1'b1);
    endtask

    task automatic t_clear_perr();
        sw_write(2'b01);
        check_all("R5 clear perr", 8'h96, 1'b1, 1'b0);
    endtask

    task automatic t_glitch();
        rx_line = 1'b0;
        repeat (3) @(negedge clk);
        rx_line = 1'b1;
        tick_bit(1'b1, 1'b0, 2'b11);
        send_char(8'hC3, 1'b0, 1'b0, 2'b11);
        check_all("R1 tick only", 8'hC3, 1'b1, 1'b0);
    endtask

    task automatic t_t1_err();
        sw_write(2'b10);
        mode_t1 = 1'b1;
        send_char(8'h55, 1'b1, 1'b0, 2'b11);
        check_all("R7 t1 error", 8'h55, 1'b1, 1'b1);
    endtask

    task automatic t_collision();
        sw_write(2'b00);
        check_all("R5 R11 clear both", 8'h55, 1'b0, 1'b0);
        send_char(8'h33, 1'b1, 1'b1, 2'b00);
        check_all("R10 set wins", 8'h33, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; rx_en = 1'b1; mode_t1 = 1'b0; odd_par = 1'b0;
        bit_tick = 1'b0; rx_line = 1'b1; wr_en = 1'b0; wr_data = 2'b11;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_good_even();
        t_clear_ready();
        t_odd();
        t_t0_err();
        t_sticky();
        t_write_one();
        t_rxen();
        t_clear_perr();
        t_glitch();
        t_t1_err();
        t_collision();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule